// File: doc/BRIEF.md
# Link-Up Supervisor with Nested Reset Retry

This block decides whether a 10G link counts as up. When asked to check, it looks at two status inputs: the link-up bit and the lane-alignment bit. The link is healthy only when both are set. If either is clear, the block sends one-cycle link-reset pulses to the PCS. After each pulse it waits a settle interval, measured in ticks of an enable input, and samples the status again. These waits and samples repeat under a nested retry scheme until the link recovers or the retry budgets run out. When the check ends, a done strobe reports the verdict.

The same check request also compares two fault counters, the local-fault count and the remote-fault count, against the values saved at the previous accepted request. If either counter has grown too far, a bad-link flag is raised. A link-status poller drives `checkReq` periodically and reads `linkUp` and `badLink` in the cycle where `done` is high. The counters and the PCS are outside this block.

Top module: `link_supervisor`

## Requirements
- R1: After reset, `linkUp`, `badLink`, `done` and `linkRst` are all 0.
- R2: When `checkReq` is accepted while `linkUpIn` and `alignIn` are both 1, `done` rises in the next cycle with `linkUp`=1, and no `linkRst` pulse is issued.
- R3: When `linkUpIn`=1 but `alignIn`=0 at request time, the reset procedure runs. `linkUp` is reported as 1 only if both status bits are 1 at some sample.
- R4: When `linkUpIn`=0 at request time, the reset procedure still runs in full. Only after it fails is the link reported down (`linkUp`=0).
- R5: Each `linkRst` pulse lasts exactly one cycle. After a pulse, the status is sampled on the SETTLE_TICKS-th `tickEn` cycle that follows the pulse cycle (default 3), and `done` follows one cycle after a good sample.
- R6: One wait budget of RETRY_MAX samples (default 4) is shared by all reset attempts:
  - The first pulse may be followed by up to RETRY_MAX samples.
  - Once the budget is spent, each further pulse gets exactly one sample.
  - At most RETRY_MAX pulses are issued.
  - A link that never recovers therefore sees 4 pulses and 7 samples (21 ticks) before `done` with `linkUp`=0.
- R7: A good sample in the middle of the sequence ends the procedure at once with `linkUp`=1, and no further pulses are issued.
- R8: At each accepted request, `badLink` becomes 1 exactly when either fault counter minus its saved value exceeds BAD_DELTA (default 250).
  - The difference is taken modulo 2^CNT_W, so a counter that wraps is handled.
  - A growth of exactly 250 gives 0.
  - Both counters are then saved.
  - The new `badLink` value is visible from the cycle after the request and holds until the next accepted request.
- R9: A `checkReq` that arrives while a check is in progress is ignored. It does not restart the procedure, does not update `badLink`, and does not replace the saved counter values.
- R10: `done` is high for exactly one cycle per accepted request. `linkUp` is valid in that cycle and changes only when `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| checkReq | input | 1 | Request a link check and a fault-counter check |
| tickEn | input | 1 | Settle-time tick enable |
| linkUpIn | input | 1 | Link-up status bit from the PCS |
| alignIn | input | 1 | Lane-alignment status bit from the PCS |
| localFaultCnt | input | CNT_W | Running local-fault counter |
| remoteFaultCnt | input | CNT_W | Running remote-fault counter |
| linkRst | output | 1 | One-cycle link-reset pulse |
| linkUp | output | 1 | Verdict of the last completed check |
| badLink | output | 1 | Fault counters grew too fast since the previous check |
| done | output | 1 | One-cycle end-of-check strobe |

## Verification
Errors in the internal retry budgets show up at the ports as pulse counts and tick counts between the first `linkRst` and `done`:
- A budget that is reloaded for each attempt shows up after the second pulse. A link that recovers after three pulses then needs 27 ticks instead of 18.
- An outer count that is off by one adds or removes a whole pulse in a run where the link never recovers.

A settle counter that is off by one moves `done` by a full tick period in the single-attempt recovery case. A saved counter value that is corrupted appears at the next accepted request as a wrong `badLink`. That is why every test with a busy-time request is followed by a clean request.

// File: rtl/lsup_pkg.sv
package lsup_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PULSE,
    ST_SETTLE,
    ST_FINISH
  } lsupState_t;

  // strobes from control to datapath and fault monitor
  typedef struct packed {
    logic loadBudgets;
    logic startSettle;
    logic countTicks;
    logic decWait;
    logic clrWait;
    logic decOuter;
    logic saveCounts;
  } lsupCtrl_t;

endpackage

// File: rtl/lsup_datapath.sv
module lsup_datapath
  import lsup_pkg::*;
#(
  parameter int RETRY_MAX    = 4,
  parameter int SETTLE_TICKS = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  lsupCtrl_t ctrl,
  input  logic      tickEn,
  output logic      settleDone,
  output logic      waitLast,
  output logic      outerLast
);

  localparam int BUD_W = $clog2(RETRY_MAX + 1);
  localparam int SET_W = $clog2(SETTLE_TICKS + 1);
  localparam logic [BUD_W-1:0] BUD_MAX = BUD_W'(RETRY_MAX);
  localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE_TICKS - 1);

  logic [SET_W-1:0] settleCnt;
  logic [BUD_W-1:0] waitLeft;
  logic [BUD_W-1:0] outerLeft;

  assign settleDone = ctrl.countTicks && tickEn && (settleCnt == SET_LAST);
  assign waitLast   = (waitLeft <= BUD_W'(1));
  assign outerLast  = (outerLeft <= BUD_W'(1));

  // settle tick counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      settleCnt <= '0;
    end else if (ctrl.startSettle || settleDone) begin
      settleCnt <= '0;
    end else if (ctrl.countTicks && tickEn) begin
      settleCnt <= settleCnt + SET_W'(1);
    end
  end

  // shared wait budget: loaded once per request, never per attempt
  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitLeft <= '0;
    end else if (ctrl.loadBudgets) begin
      waitLeft <= BUD_MAX;
    end else if (ctrl.clrWait) begin
      waitLeft <= '0;
    end else if (ctrl.decWait) begin
      waitLeft <= waitLeft - BUD_W'(1);
    end
  end

  // outer reset-attempt budget
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outerLeft <= '0;
    end else if (ctrl.loadBudgets) begin
      outerLeft <= BUD_MAX;
    end else if (ctrl.decOuter) begin
      outerLeft <= outerLeft - BUD_W'(1);
    end
  end

  p_settle_range_r5 : assert property (@(posedge clk) disable iff (!rstN)
    settleCnt < SET_W'(SETTLE_TICKS));

  p_budget_cap_r6 : assert property (@(posedge clk) disable iff (!rstN)
    (waitLeft <= BUD_MAX) && (outerLeft <= BUD_MAX));

  p_outer_after_wait_r6 : assert property (@(posedge clk) disable iff (!rstN)
    ctrl.decOuter |-> waitLast);

  p_wait_no_reload_r6 : assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.loadBudgets |=> waitLeft <= $past(waitLeft));

endmodule

// File: rtl/lsup_fault_mon.sv
module lsup_fault_mon
  import lsup_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int BAD_DELTA = 250
) (
  input  logic             clk,
  input  logic             rstN,
  input  lsupCtrl_t        ctrl,
  input  logic [CNT_W-1:0] localFaultCnt,
  input  logic [CNT_W-1:0] remoteFaultCnt,
  output logic             badLink
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(BAD_DELTA);

  logic [CNT_W-1:0] savedLocal;
  logic [CNT_W-1:0] savedRemote;
  logic [CNT_W-1:0] growLocal;
  logic [CNT_W-1:0] growRemote;

  // modular difference copes with counter wrap
  assign growLocal  = localFaultCnt - savedLocal;
  assign growRemote = remoteFaultCnt - savedRemote;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      savedLocal  <= '0;
      savedRemote <= '0;
      badLink     <= 1'b0;
    end else if (ctrl.saveCounts) begin
      savedLocal  <= localFaultCnt;
      savedRemote <= remoteFaultCnt;
      badLink     <= (growLocal > LIMIT) || (growRemote > LIMIT);
    end
  end

  p_bad_hold_r8 : assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.saveCounts |=> $stable(badLink));

endmodule

// File: rtl/lsup_control.sv
module lsup_control
  import lsup_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      checkReq,
  input  logic      linkUpIn,
  input  logic      alignIn,
  input  logic      settleDone,
  input  logic      waitLast,
  input  logic      outerLast,
  output lsupCtrl_t ctrl,
  output logic      linkRst,
  output logic      done,
  output logic      linkUp
);

  lsupState_t state;
  lsupState_t stateNext;
  logic       statusGood;
  logic       finishSet;
  logic       finishVal;

  assign statusGood = linkUpIn && alignIn;

  always_comb begin
    stateNext = state;
    ctrl      = '0;
    finishSet = 1'b0;
    finishVal = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (checkReq) begin
          ctrl.saveCounts = 1'b1;
          if (statusGood) begin
            finishSet = 1'b1;
            finishVal = 1'b1;
            stateNext = ST_FINISH;
          end else begin
            ctrl.loadBudgets = 1'b1;
            stateNext        = ST_PULSE;
          end
        end
      end
      ST_PULSE: begin
        ctrl.startSettle = 1'b1;
        stateNext        = ST_SETTLE;
      end
      ST_SETTLE: begin
        ctrl.countTicks = 1'b1;
        if (settleDone) begin
          if (statusGood) begin
            finishSet = 1'b1;
            finishVal = 1'b1;
            stateNext = ST_FINISH;
          end else if (!waitLast) begin
            ctrl.decWait = 1'b1;
          end else begin
            ctrl.clrWait = 1'b1;
            if (!outerLast) begin
              ctrl.decOuter = 1'b1;
              stateNext     = ST_PULSE;
            end else begin
              finishSet = 1'b1;
              stateNext = ST_FINISH;
            end
          end
        end
      end
      ST_FINISH: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      linkUp <= 1'b0;
    end else begin
      state <= stateNext;
      if (finishSet) linkUp <= finishVal;
    end
  end

  assign linkRst = (state == ST_PULSE);
  assign done    = (state == ST_FINISH);

  p_pulse_single_r5 : assert property (@(posedge clk) disable iff (!rstN)
    linkRst |=> !linkRst);

  p_done_single_r10 : assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_up_change_at_done_r10 : assert property (@(posedge clk) disable iff (!rstN)
    !$stable(linkUp) |-> done);

  p_up_needs_both_r3 : assert property (@(posedge clk) disable iff (!rstN)
    (done && linkUp) |-> $past(linkUpIn && alignIn));

  p_fast_no_pulse_r2 : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && checkReq && statusGood) |=> (done && !linkRst));

endmodule

// File: rtl/link_supervisor.sv
module link_supervisor
  import lsup_pkg::*;
#(
  parameter int RETRY_MAX    = 4,
  parameter int SETTLE_TICKS = 3,
  parameter int CNT_W        = 32,
  parameter int BAD_DELTA    = 250
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             checkReq,
  input  logic             tickEn,
  input  logic             linkUpIn,
  input  logic             alignIn,
  input  logic [CNT_W-1:0] localFaultCnt,
  input  logic [CNT_W-1:0] remoteFaultCnt,
  output logic             linkRst,
  output logic             linkUp,
  output logic             badLink,
  output logic             done
);

  lsupCtrl_t ctrl;
  logic      settleDone;
  logic      waitLast;
  logic      outerLast;

  lsup_control u_control (
    .clk       (clk),
    .rstN      (rstN),
    .checkReq  (checkReq),
    .linkUpIn  (linkUpIn),
    .alignIn   (alignIn),
    .settleDone(settleDone),
    .waitLast  (waitLast),
    .outerLast (outerLast),
    .ctrl      (ctrl),
    .linkRst   (linkRst),
    .done      (done),
    .linkUp    (linkUp)
  );

  lsup_datapath #(
    .RETRY_MAX   (RETRY_MAX),
    .SETTLE_TICKS(SETTLE_TICKS)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .tickEn    (tickEn),
    .settleDone(settleDone),
    .waitLast  (waitLast),
    .outerLast (outerLast)
  );

  lsup_fault_mon #(
    .CNT_W    (CNT_W),
    .BAD_DELTA(BAD_DELTA)
  ) u_fault_mon (
    .clk           (clk),
    .rstN          (rstN),
    .ctrl          (ctrl),
    .localFaultCnt (localFaultCnt),
    .remoteFaultCnt(remoteFaultCnt),
    .badLink       (badLink)
  );

endmodule

// File: tb/link_supervisor_bench.sv
module link_supervisor_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        checkReq;
  logic        tickEn;
  logic        linkUpIn;
  logic        alignIn;
  logic [31:0] localFaultCnt;
  logic [31:0] remoteFaultCnt;
  logic        linkRst;
  logic        linkUp;
  logic        badLink;
  logic        done;

  int checks   = 0;
  int failures = 0;

  always #2 clk = ~clk;

  link_supervisor u_link_supervisor (
    .clk           (clk),
    .rstN          (rstN),
    .checkReq      (checkReq),
    .tickEn        (tickEn),
    .linkUpIn      (linkUpIn),
    .alignIn       (alignIn),
    .localFaultCnt (localFaultCnt),
    .remoteFaultCnt(remoteFaultCnt),
    .linkRst       (linkRst),
    .linkUp        (linkUp),
    .badLink       (badLink),
    .done          (done)
  );

  task automatic expectEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One request; entered and left just after a rising edge.
  // goodAfter: status forced good once that many pulses are seen (-1 never).
  // busyAt: cycle of an extra request (and +1000 local faults), -1 none.
  task automatic runCheck(input bit lu, input bit al, input int goodAfter,
                          input int busyAt, output int pulses, output int ticks,
                          output int latency, output bit upOut);
    bit fin = 0;
    pulses  = 0;
    ticks   = 0;
    latency = -1;
    upOut   = 0;
    linkUpIn = lu;
    alignIn  = al;
    for (int cyc = 0; cyc < 3000 && !fin; cyc++) begin
      checkReq = (cyc == 0) || (cyc == busyAt);
      if (cyc == busyAt) localFaultCnt = localFaultCnt + 32'd1000;
      tickEn = (cyc > 0) && (cyc % 4 == 0);
      @(negedge clk);
      if (linkRst) pulses++;
      else if (pulses > 0 && tickEn && !done) ticks++;
      if (done) begin
        fin     = 1;
        latency = cyc;
        upOut   = linkUp;
      end
      if (goodAfter >= 0 && pulses >= goodAfter) begin
        linkUpIn = 1'b1;
        alignIn  = 1'b1;
      end
      @(posedge clk);
      #1;
    end
    checkReq = 1'b0;
    tickEn   = 1'b0;
    @(negedge clk);
    expectEq("R10", "done width one cycle", int'(done), 0);
    expectEq("R10", "linkUp held after done", int'(linkUp), int'(upOut));
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    @(negedge clk);
    expectEq("R1", "linkUp at reset", int'(linkUp), 0);
    expectEq("R1", "badLink at reset", int'(badLink), 0);
    expectEq("R1", "done at reset", int'(done), 0);
    expectEq("R1", "linkRst at reset", int'(linkRst), 0);
    @(posedge clk);
    #1;
  endtask

  task automatic t_fast_up;
    int p, t, lat;
    bit up;
    runCheck(1, 1, -1, -1, p, t, lat, up);
    expectEq("R2", "fast path pulses", p, 0);
    expectEq("R2", "fast path latency", lat, 1);
    expectEq("R2", "fast path linkUp", int'(up), 1);
  endtask

  task automatic t_settle_time;
    int p, t, lat;
    bit up;
    runCheck(1, 0, 1, -1, p, t, lat, up);
    expectEq("R3", "no-align recovers linkUp", int'(up), 1);
    expectEq("R5", "single pulse", p, 1);
    expectEq("R5", "ticks to sample", t, 3);
    expectEq("R5", "done latency", lat, 13);
  endtask

  task automatic t_no_align_fail;
    int p, t, lat;
    bit up;
    runCheck(1, 0, -1, -1, p, t, lat, up);
    expectEq("R3", "no-align never recovers linkUp", int'(up), 0);
    expectEq("R6", "total pulses", p, 4);
    expectEq("R6", "total ticks", t, 21);
  endtask

  task automatic t_down_fail;
    int p, t, lat;
    bit up;
    runCheck(0, 1, -1, -1, p, t, lat, up);
    expectEq("R4", "down still pulses", p, 4);
    expectEq("R4", "down ticks", t, 21);
    expectEq("R4", "down linkUp", int'(up), 0);
  endtask

  task automatic t_recover_mid;
    int p, t, lat;
    bit up;
    runCheck(0, 0, 2, -1, p, t, lat, up);
    expectEq("R7", "pulses at recovery", p, 2);
    expectEq("R7", "ticks at recovery", t, 15);
    expectEq("R7", "linkUp after recovery", int'(up), 1);
  endtask

  task automatic t_shared_budget;
    int p, t, lat;
    bit up;
    runCheck(0, 0, 3, -1, p, t, lat, up);
    expectEq("R6", "shared budget pulses", p, 3);
    expectEq("R6", "shared budget ticks", t, 18);
    expectEq("R6", "shared budget linkUp", int'(up), 1);
  endtask

  task automatic badStep(input logic [31:0] loc, input logic [31:0] rem, input int expBad,
                         input string what);
    int p, t, lat;
    bit up;
    localFaultCnt  = loc;
    remoteFaultCnt = rem;
    runCheck(1, 1, -1, -1, p, t, lat, up);
    expectEq("R8", what, int'(badLink), expBad);
  endtask

  task automatic t_bad_link;
    badStep(32'd250, 32'd0, 0, "local grew 250");
    badStep(32'd501, 32'd0, 1, "local grew 251");
    badStep(32'd501, 32'd100, 0, "remote grew 100");
    badStep(32'd501, 32'd351, 1, "remote grew 251");
    badStep(32'hFFFF_FFF0, 32'd351, 1, "local jumped large");
    badStep(32'h0000_0010, 32'd351, 0, "local wrapped by 32");
  endtask

  task automatic t_busy_ignored;
    int p, t, lat;
    bit up;
    runCheck(0, 0, -1, 10, p, t, lat, up);
    expectEq("R9", "busy request pulses", p, 4);
    expectEq("R9", "busy request ticks", t, 21);
    expectEq("R9", "busy request badLink", int'(badLink), 0);
    runCheck(1, 1, -1, -1, p, t, lat, up);
    expectEq("R9", "saved counts untouched", int'(badLink), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog: done_seen=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rstN           = 1'b0;
    checkReq       = 1'b0;
    tickEn         = 1'b0;
    linkUpIn       = 1'b0;
    alignIn        = 1'b0;
    localFaultCnt  = '0;
    remoteFaultCnt = '0;
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    t_reset();
    t_fast_up();
    t_settle_time();
    t_no_align_fail();
    t_down_fail();
    t_recover_mid();
    t_shared_budget();
    t_bad_link();
    t_busy_ignored();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule